// File: doc/BRIEF.md
# Range-Matching CAM Decision-Tree Classifier

This block evaluates one decision tree in a single parallel search, in the way a range-matching content-addressable array does. Each row of the array holds one branch of the tree, from the root down to a leaf. For every feature column, the row stores a comparison mode and a small threshold, and it also stores the class label of its leaf and a valid bit. A query vector of quantized features is compared against every row at the same time. A row hits only when every one of its cells accepts its feature, so the search returns the leaf the query reaches without walking the tree step by step.

Each cell is a one-sided comparator. In below mode the lower bound is fixed at the minimum input value, so the cell accepts features under its threshold. In at-or-above mode the upper bound is fixed at the maximum input value, so the cell accepts features equal to or over its threshold. The two modes split the range at the same point, so a tree node maps to one below cell and one at-or-above cell with equal thresholds. A don't-care cell accepts every value. It fills in features that a branch never tests and the unused depth of short branches. Wide rows are cut into sub-arrays of `SUB_W` columns that are evaluated side by side; the row hit is the AND of its sub-array hits.

Software loads the array one cell or one row at a time through a write port. Queries arrive through a valid/ready handshake at up to one per clock. The registered result gives the hit vector, the label of the winning row, a no-hit flag and a multi-hit flag.

Top module: `rmcam_tree`

## Requirements
- R1: After reset, every row is invalid, r_valid is 0, q_ready is 1, and a search returns an all-zero hit vector with r_none set.
- R2: A cell in mode 1 (below) accepts a feature f when f < thr. Features and thresholds are THR_W-bit unsigned values, and a feature occupies bits [c*THR_W +: THR_W] of q_feat for column c.
- R3: A cell in mode 2 (at-or-above) accepts a feature f when f >= thr.
- R4: A cell in mode 0 or mode 3 (don't care) accepts every feature, whatever its stored threshold.
- R5: Row r hits (r_match bit r) only when its valid bit is 1 and every cell in every sub-array of the row accepts. A row whose valid bit is 0 never hits.
- R6: A query is accepted when q_valid and q_ready are both 1. Its result appears at the first rising edge after acceptance, with r_valid 1 for exactly that cycle. While r_valid is 0, r_match, r_label, r_none and r_multi hold their previous values.
- R7: r_label is the label of the lowest-index hitting row. When no row hits, r_none is 1 and r_label is 0.
- R8: r_multi is 1 exactly when two or more rows hit.
- R9: q_ready is 0 in every cycle in which cfg_cell_we or cfg_row_we is 1, and a query presented in such a cycle is not accepted.
- R10: A cell write (cfg_cell_we) changes only the mode and threshold of cell (cfg_row, cfg_col). A row write (cfg_row_we) sets the label and valid bit of row cfg_row. Both take effect at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cell_we | input | 1 | Write mode and threshold of one cell |
| cfg_row_we | input | 1 | Write label and valid bit of one row |
| cfg_row | input | $clog2(N_ROWS) | Row address for either write |
| cfg_col | input | $clog2(N_COLS) | Column address for a cell write |
| cfg_mode | input | 2 | Cell mode: 0/3 don't care, 1 below, 2 at-or-above |
| cfg_thr | input | THR_W | Cell threshold |
| cfg_label | input | LBL_W | Row class label |
| cfg_valid | input | 1 | Row valid bit |
| q_valid | input | 1 | Query present |
| q_ready | output | 1 | Query can be accepted this cycle |
| q_feat | input | N_COLS*THR_W | Packed quantized feature vector |
| r_valid | output | 1 | Result valid, one cycle per accepted query |
| r_match | output | N_ROWS | Per-row hit vector |
| r_label | output | LBL_W | Label of lowest-index hitting row |
| r_none | output | 1 | No row hit |
| r_multi | output | 1 | Two or more rows hit |

## Verification
A depth-two tree on two features is loaded and swept over all 64 combinations of those features. Every query must then reach exactly one leaf, which shows that the below and at-or-above cells split each threshold without a gap or an overlap. Single-cell probes placed at and next to the threshold separate the strict comparison from the inclusive one, and show that a don't-care cell ignores both its threshold and its feature. A row whose only failing cell lies in the second sub-array shows that the sub-array results are combined. A catch-all row added on top of the tree forces double hits, which checks the lowest-index choice and the multi-hit flag. A random phase then mixes cell and row writes, including writes that collide with queries, into a query stream of one per cycle.

// File: rtl/rmcam_pkg.sv
package rmcam_pkg;
   typedef enum logic [1:0] {
      CM_ANY     = 2'd0,
      CM_BELOW   = 2'd1,
      CM_ATLEAST = 2'd2,
      CM_ANY_ALT = 2'd3
   } cmp_mode_e;
endpackage

// File: rtl/rmcam_cell.sv
module rmcam_cell #(
   parameter int THR_W = 3
) (
   input  logic [THR_W-1:0] feat,
   input  logic [1:0]       mode,
   input  logic [THR_W-1:0] thr,
   output logic             hit
);
   import rmcam_pkg::*;

   always_comb begin
      case (cmp_mode_e'(mode))
         CM_BELOW:   hit = (feat < thr);
         CM_ATLEAST: hit = (feat >= thr);
         default:    hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/rmcam_row.sv
module rmcam_row #(
   parameter int N_COLS = 4,
   parameter int SUB_W  = 2,
   parameter int THR_W  = 3
) (
   input  logic [N_COLS*THR_W-1:0] feat,
   input  logic [N_COLS*2-1:0]     modes,
   input  logic [N_COLS*THR_W-1:0] thrs,
   input  logic                    valid,
   output logic                    hit
);
   localparam int N_SUB = (N_COLS + SUB_W - 1) / SUB_W;

   logic [N_COLS-1:0] cell_hit;

   for (genvar c = 0; c < N_COLS; c++) begin : g_cell
      rmcam_cell #(.THR_W(THR_W)) u_cell (
         .feat (feat[c*THR_W +: THR_W]),
         .mode (modes[c*2 +: 2]),
         .thr  (thrs[c*THR_W +: THR_W]),
         .hit  (cell_hit[c])
      );
   end

   if (N_SUB == 1) begin : g_flat
      assign hit = valid & (&cell_hit);
   end else begin : g_split
      logic [N_SUB-1:0] sub_hit;
      for (genvar s = 0; s < N_SUB; s++) begin : g_sub
         localparam int LO = s * SUB_W;
         localparam int HI = (LO + SUB_W > N_COLS) ? N_COLS - 1 : LO + SUB_W - 1;
         assign sub_hit[s] = &cell_hit[HI:LO];
      end
      assign hit = valid & (&sub_hit);
   end
endmodule

// File: rtl/rmcam_prio.sv
module rmcam_prio #(
   parameter int N_ROWS = 8,
   parameter int LBL_W  = 4
) (
   input  logic [N_ROWS-1:0]       hits,
   input  logic [N_ROWS*LBL_W-1:0] labels,
   output logic [LBL_W-1:0]        label,
   output logic                    none,
   output logic                    multi
);
   localparam logic [N_ROWS-1:0] ONE = {{(N_ROWS-1){1'b0}}, 1'b1};

   always_comb begin
      label = '0;
      for (int i = N_ROWS - 1; i >= 0; i--) begin
         if (hits[i]) label = labels[i*LBL_W +: LBL_W];
      end
   end

   assign none  = (hits == '0);
   assign multi = ((hits & (hits - ONE)) != '0);
endmodule

// File: rtl/rmcam_tree.sv
module rmcam_tree #(
   parameter int N_ROWS = 8,
   parameter int N_COLS = 4,
   parameter int SUB_W  = 2,
   parameter int THR_W  = 3,
   parameter int LBL_W  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_cell_we,
   input  logic                      cfg_row_we,
   input  logic [$clog2(N_ROWS)-1:0] cfg_row,
   input  logic [$clog2(N_COLS)-1:0] cfg_col,
   input  logic [1:0]                cfg_mode,
   input  logic [THR_W-1:0]          cfg_thr,
   input  logic [LBL_W-1:0]          cfg_label,
   input  logic                      cfg_valid,
   input  logic                      q_valid,
   output logic                      q_ready,
   input  logic [N_COLS*THR_W-1:0]   q_feat,
   output logic                      r_valid,
   output logic [N_ROWS-1:0]         r_match,
   output logic [LBL_W-1:0]          r_label,
   output logic                      r_none,
   output logic                      r_multi
);
   if (N_ROWS < 2) begin : g_bad_rows
      $error("rmcam_tree: N_ROWS must be at least 2");
   end
   if (N_COLS < 2) begin : g_bad_cols
      $error("rmcam_tree: N_COLS must be at least 2");
   end
   if (SUB_W < 1 || SUB_W > N_COLS) begin : g_bad_sub
      $error("rmcam_tree: SUB_W must lie in 1..N_COLS");
   end
   if (THR_W < 1 || LBL_W < 1) begin : g_bad_w
      $error("rmcam_tree: THR_W and LBL_W must be positive");
   end

   logic [1:0]       mode_q [N_ROWS][N_COLS];
   logic [THR_W-1:0] thr_q  [N_ROWS][N_COLS];
   logic [LBL_W-1:0] lbl_q  [N_ROWS];
   logic             vld_q  [N_ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < N_ROWS; r++) begin
            lbl_q[r] <= '0;
            vld_q[r] <= 1'b0;
            for (int c = 0; c < N_COLS; c++) begin
               mode_q[r][c] <= 2'd0;
               thr_q[r][c]  <= '0;
            end
         end
      end else begin
         for (int r = 0; r < N_ROWS; r++) begin
            if (cfg_row_we && int'(cfg_row) == r) begin
               lbl_q[r] <= cfg_label;
               vld_q[r] <= cfg_valid;
            end
            for (int c = 0; c < N_COLS; c++) begin
               if (cfg_cell_we && int'(cfg_row) == r && int'(cfg_col) == c) begin
                  mode_q[r][c] <= cfg_mode;
                  thr_q[r][c]  <= cfg_thr;
               end
            end
         end
      end
   end

   logic [N_ROWS-1:0]       row_hit;
   logic [N_ROWS*LBL_W-1:0] lbl_flat;

   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      logic [N_COLS*2-1:0]     modes_flat;
      logic [N_COLS*THR_W-1:0] thrs_flat;
      for (genvar c = 0; c < N_COLS; c++) begin : g_pack
         assign modes_flat[c*2 +: 2]        = mode_q[r][c];
         assign thrs_flat[c*THR_W +: THR_W] = thr_q[r][c];
      end
      assign lbl_flat[r*LBL_W +: LBL_W] = lbl_q[r];

      rmcam_row #(.N_COLS(N_COLS), .SUB_W(SUB_W), .THR_W(THR_W)) u_row (
         .feat  (q_feat),
         .modes (modes_flat),
         .thrs  (thrs_flat),
         .valid (vld_q[r]),
         .hit   (row_hit[r])
      );
   end

   logic [LBL_W-1:0] pick_label;
   logic             pick_none;
   logic             pick_multi;

   rmcam_prio #(.N_ROWS(N_ROWS), .LBL_W(LBL_W)) u_prio (
      .hits   (row_hit),
      .labels (lbl_flat),
      .label  (pick_label),
      .none   (pick_none),
      .multi  (pick_multi)
   );

   assign q_ready = !(cfg_cell_we || cfg_row_we);

   logic accept;
   assign accept = q_valid && q_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_valid <= 1'b0;
         r_match <= '0;
         r_label <= '0;
         r_none  <= 1'b0;
         r_multi <= 1'b0;
      end else begin
         r_valid <= accept;
         if (accept) begin
            r_match <= row_hit;
            r_label <= pick_label;
            r_none  <= pick_none;
            r_multi <= pick_multi;
         end
      end
   end
endmodule

// File: rtl/rmcam_tree_chk.sv
module rmcam_tree_chk #(
   parameter int N_ROWS = 8,
   parameter int LBL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_cell_we,
   input logic              cfg_row_we,
   input logic              q_valid,
   input logic              q_ready,
   input logic              r_valid,
   input logic [N_ROWS-1:0] r_match,
   input logic [LBL_W-1:0]  r_label,
   input logic              r_none,
   input logic              r_multi
);
   p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid && q_ready) |=> r_valid);

   p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_valid && q_ready) |=> !r_valid);

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !r_valid |-> ($stable(r_match) && $stable(r_label) && $stable(r_none) && $stable(r_multi)));

   p_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |-> (r_none == (r_match == '0)));

   p_empty_label_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (r_valid && r_none) |-> (r_label == '0));

   p_multi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |-> (r_multi == ($countones(r_match) > 1)));

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cell_we || cfg_row_we) |-> !q_ready);
endmodule

bind rmcam_tree rmcam_tree_chk #(.N_ROWS(N_ROWS), .LBL_W(LBL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_cell_we (cfg_cell_we),
   .cfg_row_we  (cfg_row_we),
   .q_valid     (q_valid),
   .q_ready     (q_ready),
   .r_valid     (r_valid),
   .r_match     (r_match),
   .r_label     (r_label),
   .r_none      (r_none),
   .r_multi     (r_multi)
);

// File: tb/sim_rmcam_tree.sv
`timescale 1ns/1ps
module sim_rmcam_tree;
   localparam int NR = 8;
   localparam int NC = 4;
   localparam int TW = 3;
   localparam int LW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_cell_we = 1'b0, cfg_row_we = 1'b0;
   logic [$clog2(NR)-1:0] cfg_row = '0;
   logic [$clog2(NC)-1:0] cfg_col = '0;
   logic [1:0] cfg_mode = '0;
   logic [TW-1:0] cfg_thr = '0;
   logic [LW-1:0] cfg_label = '0;
   logic cfg_valid = 1'b0;
   logic q_valid = 1'b0;
   logic q_ready;
   logic [NC*TW-1:0] q_feat = '0;
   logic r_valid;
   logic [NR-1:0] r_match;
   logic [LW-1:0] r_label;
   logic r_none, r_multi;

   always #2 clk = ~clk;

   rmcam_tree #(.N_ROWS(NR), .N_COLS(NC), .SUB_W(2), .THR_W(TW), .LBL_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_cell_we(cfg_cell_we), .cfg_row_we(cfg_row_we),
      .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_mode(cfg_mode), .cfg_thr(cfg_thr),
      .cfg_label(cfg_label), .cfg_valid(cfg_valid), .q_valid(q_valid), .q_ready(q_ready),
      .q_feat(q_feat), .r_valid(r_valid), .r_match(r_match), .r_label(r_label),
      .r_none(r_none), .r_multi(r_multi)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   logic [1:0]    m_mode [NR][NC];
   logic [TW-1:0] m_thr  [NR][NC];
   logic [LW-1:0] m_lbl  [NR];
   logic          m_vld  [NR];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [NR-1:0] f_hits(input logic [NC*TW-1:0] q);
      logic [NR-1:0] h;
      for (int r = 0; r < NR; r++) begin
         h[r] = m_vld[r];
         for (int c = 0; c < NC; c++) begin
            logic [TW-1:0] fv;
            fv = q[c*TW +: TW];
            if (m_mode[r][c] == 2'd1 && !(fv < m_thr[r][c])) h[r] = 1'b0;
            if (m_mode[r][c] == 2'd2 && !(fv >= m_thr[r][c])) h[r] = 1'b0;
         end
      end
      return h;
   endfunction

   function automatic logic [LW-1:0] f_label(input logic [NR-1:0] h);
      logic [LW-1:0] l;
      l = '0;
      for (int r = NR - 1; r >= 0; r--) if (h[r]) l = m_lbl[r];
      return l;
   endfunction

   task automatic chk_res(input string tag, input logic ev, input logic [NR-1:0] em,
                          input logic [LW-1:0] el);
      chk({tag, " valid"}, 64'(r_valid), 64'(ev));
      chk({tag, " match"}, 64'(r_match), 64'(em));
      chk({tag, " label"}, 64'(r_label), 64'(el));
      chk({tag, " none"},  64'(r_none),  64'(em == '0));
      chk({tag, " multi"}, 64'(r_multi), 64'($countones(em) > 1));
   endtask

   task automatic wr_cell(input int r, input int c, input logic [1:0] md, input logic [TW-1:0] th);
      @(negedge clk);
      cfg_cell_we = 1'b1; cfg_row = r[$clog2(NR)-1:0]; cfg_col = c[$clog2(NC)-1:0];
      cfg_mode = md; cfg_thr = th;
      #1 chk("R9 ready low during cell write", 64'(q_ready), 64'd0);
      @(negedge clk);
      cfg_cell_we = 1'b0;
      m_mode[r][c] = md; m_thr[r][c] = th;
   endtask

   task automatic wr_row(input int r, input logic [LW-1:0] lb, input logic v);
      @(negedge clk);
      cfg_row_we = 1'b1; cfg_row = r[$clog2(NR)-1:0]; cfg_label = lb; cfg_valid = v;
      @(negedge clk);
      cfg_row_we = 1'b0;
      m_lbl[r] = lb; m_vld[r] = v;
   endtask

   task automatic search(input string tag, input logic [NC*TW-1:0] q);
      logic [NR-1:0] h;
      @(negedge clk);
      q_valid = 1'b1; q_feat = q;
      h = f_hits(q);
      @(negedge clk);
      q_valid = 1'b0;
      chk_res(tag, 1'b1, h, f_label(h));
   endtask

   function automatic logic [NC*TW-1:0] mkq(input int f0, input int f1, input int f2, input int f3);
      return {f3[TW-1:0], f2[TW-1:0], f1[TW-1:0], f0[TW-1:0]};
   endfunction

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int r = 0; r < NR; r++) begin
         m_lbl[r] = '0; m_vld[r] = 1'b0;
         for (int c = 0; c < NC; c++) begin m_mode[r][c] = 2'd0; m_thr[r][c] = '0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 r_valid after reset", 64'(r_valid), 64'd0);
      chk("R1 q_ready after reset", 64'(q_ready), 64'd1);
      search("R1 empty array", mkq(1, 2, 3, 4));
      chk("R1 no hit after reset", 64'(r_none), 64'd1);

      // R2: below mode, strict
      wr_row(0, 4'd5, 1'b1);
      wr_cell(0, 0, 2'd1, 3'd4);
      search("R2 f=3 below 4", mkq(3, 7, 0, 5));
      chk("R2 hit at 3", 64'(r_match[0]), 64'd1);
      search("R2 f=4 not below 4", mkq(4, 7, 0, 5));
      chk("R2 miss at 4", 64'(r_match[0]), 64'd0);
      // R3: at-or-above mode, inclusive
      wr_cell(0, 0, 2'd2, 3'd4);
      search("R3 f=4 at-or-above 4", mkq(4, 0, 0, 0));
      chk("R3 hit at 4", 64'(r_match[0]), 64'd1);
      search("R3 f=3 under 4", mkq(3, 0, 0, 0));
      chk("R3 miss at 3", 64'(r_match[0]), 64'd0);
      // R4: don't care, mode 3 and mode 0 with nonzero threshold
      wr_cell(0, 0, 2'd3, 3'd7);
      search("R4 mode3 f=0", mkq(0, 0, 0, 0));
      chk("R4 mode3 hit", 64'(r_match[0]), 64'd1);
      wr_cell(0, 0, 2'd0, 3'd0);
      search("R4 mode0 f=7", mkq(7, 7, 7, 7));
      chk("R4 mode0 hit", 64'(r_match[0]), 64'd1);
      // R5: failure only in second sub-array (column 3)
      wr_cell(0, 3, 2'd1, 3'd2);
      search("R5 col3 fails", mkq(0, 0, 0, 5));
      chk("R5 second sub-array blocks row", 64'(r_match[0]), 64'd0);
      search("R5 col3 passes", mkq(0, 0, 0, 1));
      chk("R5 row hits", 64'(r_match[0]), 64'd1);
      wr_row(0, 4'd5, 1'b0);
      search("R5 invalid row", mkq(0, 0, 0, 1));
      chk("R5 invalid never hits", 64'(r_match[0]), 64'd0);
      // R6: result valid one cycle only, then hold
      search("R6 single result", mkq(0, 0, 0, 0));
      @(negedge clk);
      chk_res("R6 hold after result", 1'b0, '0, '0);

      // R7: depth-two tree over features 0 and 1, exhaustive sweep
      wr_cell(0, 3, 2'd0, 3'd0);
      wr_cell(0, 0, 2'd1, 3'd4); wr_cell(0, 1, 2'd1, 3'd2); wr_row(0, 4'd1, 1'b1);
      wr_cell(1, 0, 2'd1, 3'd4); wr_cell(1, 1, 2'd2, 3'd2); wr_row(1, 4'd2, 1'b1);
      wr_cell(2, 0, 2'd2, 3'd4); wr_cell(2, 1, 2'd1, 3'd6); wr_row(2, 4'd3, 1'b1);
      wr_cell(3, 0, 2'd2, 3'd4); wr_cell(3, 1, 2'd2, 3'd6); wr_row(3, 4'd4, 1'b1);
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            search("R7 tree sweep", mkq(a, b, b, a));
            chk("R7 exactly one leaf", 64'($countones(r_match)), 64'd1);
         end
      end
      // R8: catch-all row 5 overlaps the tree
      wr_row(5, 4'd9, 1'b1);
      search("R8 double hit", mkq(6, 7, 0, 0));
      chk("R8 multi set", 64'(r_multi), 64'd1);
      chk("R7 lowest row label", 64'(r_label), 64'd4);
      // R9: query colliding with a write is dropped
      @(negedge clk);
      q_valid = 1'b1; q_feat = mkq(1, 1, 1, 1);
      cfg_row_we = 1'b1; cfg_row = 3'd6; cfg_label = 4'd11; cfg_valid = 1'b0;
      @(negedge clk);
      q_valid = 1'b0; cfg_row_we = 1'b0;
      m_lbl[6] = 4'd11; m_vld[6] = 1'b0;
      chk("R9 colliding query not accepted", 64'(r_valid), 64'd0);
      // R10: cell write touches only its cell
      wr_cell(5, 2, 2'd1, 3'd1);
      search("R10 addressed cell changed", mkq(0, 0, 3, 0));
      chk("R10 row5 now blocked", 64'(r_match[5]), 64'd0);
      chk("R10 row0 untouched", 64'(r_match[0]), 64'd1);

      // random phase, one query per cycle, expectations carried one cycle
      begin
         logic ev;
         logic [NR-1:0] em;
         logic [LW-1:0] el;
         ev = 1'b0; em = r_match; el = r_label;
         for (int i = 0; i < 3000; i++) begin
            int act;
            @(negedge clk);
            if (i > 0) chk_res("R10 random stream", ev, em, el);
            q_valid = 1'b0; cfg_cell_we = 1'b0; cfg_row_we = 1'b0;
            act = int'($urandom_range(0, 99));
            q_feat = NC*TW'($urandom);
            if (act < 70) q_valid = 1'b1;
            if (act >= 60 && act < 85) begin
               cfg_cell_we = 1'b1;
               cfg_row = $clog2(NR)'($urandom); cfg_col = $clog2(NC)'($urandom);
               cfg_mode = 2'($urandom); cfg_thr = TW'($urandom);
            end else if (act >= 85) begin
               cfg_row_we = 1'b1; cfg_row = $clog2(NR)'($urandom);
               cfg_label = LW'($urandom); cfg_valid = ($urandom_range(0, 3) != 0);
            end
            if (q_valid && !cfg_cell_we && !cfg_row_we) begin
               ev = 1'b1; em = f_hits(q_feat); el = f_label(em);
            end else begin
               ev = 1'b0;
            end
            if (cfg_cell_we) begin
               m_mode[cfg_row][cfg_col] = cfg_mode; m_thr[cfg_row][cfg_col] = cfg_thr;
            end
            if (cfg_row_we) begin
               m_lbl[cfg_row] = cfg_label; m_vld[cfg_row] = cfg_valid;
            end
         end
         @(negedge clk);
         chk_res("R10 random stream", ev, em, el);
         q_valid = 1'b0; cfg_cell_we = 1'b0; cfg_row_we = 1'b0;
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule